// File: doc/BRIEF.md
# Buffer Descriptor Stream DMA

This block moves audio sample bytes between system memory and a codec link for a set of independent streams. Each stream is described by a short list of buffer descriptors in memory. Each descriptor gives a buffer address, a length and a flags word. Starting a stream makes the engine read the whole list into local storage. After that, each transfer request from the link side is served by walking the list.

A request names a stream tag, a direction and a byte count. The engine breaks it into memory moves. No move crosses the end of a descriptor or the end of the stream's cyclic buffer. The engine tracks the link position, the descriptor index and the offset inside the current descriptor. A descriptor that asks for an interrupt raises the stream's completion bit once it has been used up. While that bit is set, the stream refuses further requests until software clears it. If position reporting is enabled, the engine can also write the link position back to memory.

Configuration goes through a narrow write port. Transfer requests use a hold-until-done handshake. All memory traffic leaves through one request/response port with one request outstanding at a time.

Top module: `bdesc_stream_dma`

## Requirements
- R1: When the run bit (control bit 1) of a stopped stream is written to 1, the engine reads last-index+1 descriptors before any data move. Each read is 16 bytes at list-base + 16*i, for i counting up from 0, with memWrite=0. The response word is decoded little-endian: bits [63:0] are the buffer address, [95:64] the length and [127:96] the flags.
- R2: A request is served by the lowest-numbered stream whose control bits [23:20] equal xferTag. If no stream matches, or the matching stream is not running, the request is refused: xferDone pulses with xferOk=0 and no memory request is made.
- R3: While a stream's completion bit (control bit 26, visible on cmplPend) is set, its requests are refused with no memory request. Writing the control register with bit 26 set clears the completion bit.
- R4: Each data move has length min(bytes still requested, cyclic length - link position, descriptor length - offset). Its address is the descriptor address plus the offset. memWrite is 0 when xferToLink=1 and 1 when xferToLink=0.
- R5: When a move uses up a descriptor, the offset returns to 0 and the index advances. After the last index it wraps to 0.
- R6: If a used-up descriptor has flags bit 0 set, the stream's completion bit is set on the clock edge that ends the xferDone cycle.
- R7: The link position returns to 0 when it reaches the cyclic length.
- R8: If bit 0 of the position-base low word is 1, each accepted request ends with one 4-byte write. The write carries the new link position and goes to the 64-bit position base with bit 0 cleared, plus 8 times the stream number.
- R9: Writing the control register with bit 0 set stops the stream and clears its link position and completion bit. Later requests to it are refused.
- R10: Restarting a stream clears the link position, index and offset, so the first move after a restart uses descriptor 0 at offset 0.
- R11: While memValid is high and memReady is low, memValid, memAddr, memLen and memWrite hold steady. A new request is issued only after memRespValid answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgStream | input | 2 | Stream written by cfgWe, also selects posOut |
| cfgSel | input | 3 | Field: 0 control, 1 cyclic length, 2 last index, 3/4 list base low/high, 5/6 position base low/high |
| cfgData | input | 32 | Configuration write data |
| posOut | output | 32 | Link position of stream cfgStream |
| cmplPend | output | 4 | Completion bit of each stream |
| xferValid | input | 1 | Transfer request, held until xferDone |
| xferTag | input | 4 | Stream tag of the request |
| xferToLink | input | 1 | 1: memory to link, 0: link to memory |
| xferLen | input | 16 | Requested byte count |
| xferDone | output | 1 | One-cycle end of request |
| xferOk | output | 1 | Request accepted (valid with xferDone) |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory request accepted |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 64 | Memory byte address |
| memLen | output | 16 | Memory request byte count |
| memWData | output | 32 | Position value for position writes |
| memRespValid | input | 1 | Response to the outstanding request |
| memRData | input | 128 | Read data (descriptor) |

## Verification
A memory request shows up on the port in the cycle after the engine leaves idle or after the previous response. The bench samples it at the falling edge of each cycle where memValid and memReady are both high, so a stalled request is counted once. xferDone rises one cycle after the last response and is compared at that falling edge. cmplPend and posOut change on the edge that closes the done cycle or the configuration write, so the bench reads them one falling edge later.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam int NUM_STREAMS = 4;
  localparam int DESC_DEPTH  = 4;
  localparam int LEN_W       = 16;

  localparam int CTL_RST  = 0;
  localparam int CTL_RUN  = 1;
  localparam int CTL_TAG  = 20;
  localparam int CTL_CMPL = 26;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_CYCLEN  = 3'd1,
    SEL_LASTIDX = 3'd2,
    SEL_LIST_LO = 3'd3,
    SEL_LIST_HI = 3'd4,
    SEL_POS_LO  = 3'd5,
    SEL_POS_HI  = 3'd6
  } cfgSel_e;

  typedef struct packed {
    logic descWr;
    logic fetchDone;
    logic advance;
    logic setCmpl;
  } dmaStrobe_t;
endpackage

// File: rtl/bdesc_dma_dpath.sv
module bdesc_dma_dpath
  import bdma_pkg::*;
#(
  parameter int NS    = NUM_STREAMS,
  parameter int DD    = DESC_DEPTH,
  parameter int LW    = LEN_W,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1,
  localparam int IW   = (DD > 1) ? $clog2(DD) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgStream,
  input  logic [2:0]    cfgSel,
  input  logic [31:0]   cfgData,
  input  dmaStrobe_t    strobe,
  input  logic [SW-1:0] curStream,
  input  logic [IW-1:0] fetchCnt,
  input  logic [LW-1:0] left,
  input  logic [127:0]  memRData,
  output logic [NS-1:0] runVec,
  output logic [NS-1:0] cmplVec,
  output logic [NS-1:0] fetchPendVec,
  output logic [NS*4-1:0] tagFlat,
  output logic [IW-1:0] fetchLast,
  output logic [63:0]   fetchAddr,
  output logic [LW-1:0] chunk,
  output logic [63:0]   moveAddr,
  output logic          willIrq,
  output logic          posEn,
  output logic [63:0]   posWrAddr,
  output logic [31:0]   posWrData,
  output logic [31:0]   posOut
);
  logic [NS-1:0] runQ, cmplQ, fetchPendQ;
  logic [3:0]    tagQ      [NS];
  logic [31:0]   cycLenQ   [NS];
  logic [31:0]   posQ      [NS];
  logic [31:0]   offQ      [NS];
  logic [IW-1:0] idxQ      [NS];
  logic [IW-1:0] lastIdxQ  [NS];
  logic [63:0]   listBaseQ [NS];
  logic [63:0]   posBaseQ;

  logic [63:0]   dAddrQ [NS][DD];
  logic [31:0]   dLenQ  [NS][DD];
  logic [DD-1:0] dIrqQ  [NS];

  logic [IW-1:0] curIdx;
  logic [31:0]   curLen, curOff, curPos, toBufEnd, toDescEnd, chunkW;
  logic [31:0]   offNext, posSum, posNext;
  logic          descEnd;

  genvar gs;
  generate
    for (gs = 0; gs < NS; gs++) begin : g_tag
      assign tagFlat[gs*4 +: 4] = tagQ[gs];
    end
  endgenerate

  assign runVec       = runQ;
  assign cmplVec      = cmplQ;
  assign fetchPendVec = fetchPendQ;

  always_comb begin
    curIdx    = idxQ[curStream];
    curLen    = dLenQ[curStream][curIdx];
    curOff    = offQ[curStream];
    curPos    = posQ[curStream];
    toBufEnd  = cycLenQ[curStream] - curPos;
    toDescEnd = curLen - curOff;
    chunkW    = {{(32-LW){1'b0}}, left};
    if (toBufEnd < chunkW)  chunkW = toBufEnd;
    if (toDescEnd < chunkW) chunkW = toDescEnd;
    chunk     = chunkW[LW-1:0];
    moveAddr  = dAddrQ[curStream][curIdx] + {32'b0, curOff};
    offNext   = curOff + chunkW;
    descEnd   = (offNext == curLen);
    willIrq   = descEnd && dIrqQ[curStream][curIdx];
    posSum    = curPos + chunkW;
    posNext   = (posSum == cycLenQ[curStream]) ? 32'd0 : posSum;
  end

  assign fetchLast = lastIdxQ[curStream];
  assign fetchAddr = listBaseQ[curStream] + {{(60-IW){1'b0}}, fetchCnt, 4'b0000};
  assign posEn     = posBaseQ[0];
  assign posWrAddr = {posBaseQ[63:1], 1'b0} + {{(61-SW){1'b0}}, curStream, 3'b000};
  assign posWrData = posQ[curStream];
  assign posOut    = posQ[cfgStream];

  // descriptor storage: written only by fetches, needs no reset
  always_ff @(posedge clk) begin
    if (strobe.descWr) begin
      dAddrQ[curStream][fetchCnt] <= memRData[63:0];
      dLenQ[curStream][fetchCnt]  <= memRData[95:64];
      dIrqQ[curStream][fetchCnt]  <= memRData[96];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ       <= '0;
      cmplQ      <= '0;
      fetchPendQ <= '0;
      posBaseQ   <= '0;
      for (int s = 0; s < NS; s++) begin
        tagQ[s]      <= '0;
        cycLenQ[s]   <= '0;
        posQ[s]      <= '0;
        offQ[s]      <= '0;
        idxQ[s]      <= '0;
        lastIdxQ[s]  <= '0;
        listBaseQ[s] <= '0;
      end
    end else begin
      if (strobe.advance) begin
        posQ[curStream] <= posNext;
        if (descEnd) begin
          offQ[curStream] <= '0;
          idxQ[curStream] <= (curIdx == lastIdxQ[curStream]) ? '0 : curIdx + 1'b1;
        end else begin
          offQ[curStream] <= offNext;
        end
      end
      if (strobe.setCmpl)   cmplQ[curStream]      <= 1'b1;
      if (strobe.fetchDone) fetchPendQ[curStream] <= 1'b0;
      if (cfgWe) begin
        unique case (cfgSel)
          SEL_CTRL: begin
            if (cfgData[CTL_RST]) begin
              runQ[cfgStream]       <= 1'b0;
              fetchPendQ[cfgStream] <= 1'b0;
              cmplQ[cfgStream]      <= 1'b0;
              posQ[cfgStream]       <= '0;
              offQ[cfgStream]       <= '0;
              idxQ[cfgStream]       <= '0;
            end else begin
              runQ[cfgStream] <= cfgData[CTL_RUN];
              tagQ[cfgStream] <= cfgData[CTL_TAG +: 4];
              if (cfgData[CTL_CMPL]) cmplQ[cfgStream] <= 1'b0;
              if (!cfgData[CTL_RUN]) fetchPendQ[cfgStream] <= 1'b0;
              else if (!runQ[cfgStream]) begin
                fetchPendQ[cfgStream] <= 1'b1;
                posQ[cfgStream]       <= '0;
                offQ[cfgStream]       <= '0;
                idxQ[cfgStream]       <= '0;
              end
            end
          end
          SEL_CYCLEN:  cycLenQ[cfgStream]         <= cfgData;
          SEL_LASTIDX: lastIdxQ[cfgStream]        <= cfgData[IW-1:0];
          SEL_LIST_LO: listBaseQ[cfgStream][31:0] <= cfgData;
          SEL_LIST_HI: listBaseQ[cfgStream][63:32] <= cfgData;
          SEL_POS_LO:  posBaseQ[31:0]             <= cfgData;
          SEL_POS_HI:  posBaseQ[63:32]            <= cfgData;
          default: ;
        endcase
      end
    end
  end

  AST_POS_WRAPPED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !cfgWe |=> posQ[$past(curStream)] != cycLenQ[$past(curStream)]); // R7
  AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !cfgWe && idxQ[curStream] <= lastIdxQ[curStream]
    |=> idxQ[$past(curStream)] <= lastIdxQ[$past(curStream)]); // R5
endmodule

// File: rtl/bdesc_dma_ctrl.sv
module bdesc_dma_ctrl
  import bdma_pkg::*;
#(
  parameter int NS    = NUM_STREAMS,
  parameter int DD    = DESC_DEPTH,
  parameter int LW    = LEN_W,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1,
  localparam int IW   = (DD > 1) ? $clog2(DD) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xferValid,
  input  logic [3:0]    xferTag,
  input  logic          xferToLink,
  input  logic [LW-1:0] xferLen,
  output logic          xferDone,
  output logic          xferOk,
  output logic          memValid,
  input  logic          memReady,
  output logic          memWrite,
  output logic [63:0]   memAddr,
  output logic [LW-1:0] memLen,
  output logic [31:0]   memWData,
  input  logic          memRespValid,
  input  logic [NS-1:0] runVec,
  input  logic [NS-1:0] cmplVec,
  input  logic [NS-1:0] fetchPendVec,
  input  logic [NS*4-1:0] tagFlat,
  input  logic [IW-1:0] fetchLast,
  input  logic [63:0]   fetchAddr,
  input  logic [LW-1:0] chunk,
  input  logic [63:0]   moveAddr,
  input  logic          willIrq,
  input  logic          posEn,
  input  logic [63:0]   posWrAddr,
  input  logic [31:0]   posWrData,
  output dmaStrobe_t    strobe,
  output logic [SW-1:0] curStream,
  output logic [IW-1:0] fetchCnt,
  output logic [LW-1:0] left
);
  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_MREQ, S_MWAIT, S_PREQ, S_PWAIT, S_DONE
  } state_e;

  state_e        state;
  logic          dirQ, irqPend, okQ;
  logic          matchHit, pendAny;
  logic [SW-1:0] matchSel, pendSel;

  always_comb begin
    matchHit = 1'b0;
    matchSel = '0;
    pendAny  = 1'b0;
    pendSel  = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (tagFlat[s*4 +: 4] == xferTag) begin
        matchHit = 1'b1;
        matchSel = SW'(s);
      end
      if (fetchPendVec[s]) begin
        pendAny = 1'b1;
        pendSel = SW'(s);
      end
    end
  end

  always_comb begin
    memValid = 1'b0;
    memWrite = 1'b0;
    memAddr  = '0;
    memLen   = '0;
    unique case (state)
      S_FREQ: begin memValid = 1'b1; memAddr = fetchAddr; memLen = LW'(16); end
      S_MREQ: begin memValid = 1'b1; memAddr = moveAddr;  memLen = chunk; memWrite = !dirQ; end
      S_PREQ: begin memValid = 1'b1; memAddr = posWrAddr; memLen = LW'(4); memWrite = 1'b1; end
      default: ;
    endcase
  end

  assign memWData         = posWrData;
  assign xferDone         = (state == S_DONE);
  assign xferOk           = okQ;
  assign strobe.descWr    = (state == S_FWAIT) && memRespValid;
  assign strobe.fetchDone = strobe.descWr && (fetchCnt == fetchLast);
  assign strobe.advance   = (state == S_MWAIT) && memRespValid;
  assign strobe.setCmpl   = (state == S_DONE) && okQ && irqPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      curStream <= '0;
      fetchCnt  <= '0;
      left      <= '0;
      dirQ      <= 1'b0;
      irqPend   <= 1'b0;
      okQ       <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (pendAny) begin
            curStream <= pendSel;
            fetchCnt  <= '0;
            state     <= S_FREQ;
          end else if (xferValid) begin
            if (!matchHit || !runVec[matchSel] || cmplVec[matchSel]) begin
              okQ   <= 1'b0;
              state <= S_DONE;
            end else begin
              curStream <= matchSel;
              left      <= xferLen;
              dirQ      <= xferToLink;
              irqPend   <= 1'b0;
              okQ       <= 1'b1;
              if (xferLen != '0) state <= S_MREQ;
              else               state <= posEn ? S_PREQ : S_DONE;
            end
          end
        end
        S_FREQ: if (memReady) state <= S_FWAIT;
        S_FWAIT: if (memRespValid) begin
          if (fetchCnt == fetchLast) state <= S_IDLE;
          else begin
            fetchCnt <= fetchCnt + 1'b1;
            state    <= S_FREQ;
          end
        end
        S_MREQ: if (memReady) state <= S_MWAIT;
        S_MWAIT: if (memRespValid) begin
          left    <= left - chunk;
          irqPend <= irqPend | willIrq;
          if (left == chunk) state <= posEn ? S_PREQ : S_DONE;
          else               state <= S_MREQ;
        end
        S_PREQ:  if (memReady) state <= S_PWAIT;
        S_PWAIT: if (memRespValid) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memLen) && $stable(memWrite)); // R11
  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rstN)
    state == S_MREQ |-> chunk != '0 && chunk <= left); // R4
  AST_NO_MOVE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    state == S_MREQ |-> runVec[curStream] && !cmplVec[curStream]); // R3
  AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    state == S_MREQ |-> !fetchPendVec[curStream]); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone); // R2
endmodule

// File: rtl/bdesc_stream_dma.sv
module bdesc_stream_dma
  import bdma_pkg::*;
#(
  parameter int NS    = NUM_STREAMS,
  parameter int DD    = DESC_DEPTH,
  parameter int LW    = LEN_W,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1,
  localparam int IW   = (DD > 1) ? $clog2(DD) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgStream,
  input  logic [2:0]    cfgSel,
  input  logic [31:0]   cfgData,
  output logic [31:0]   posOut,
  output logic [NS-1:0] cmplPend,
  input  logic          xferValid,
  input  logic [3:0]    xferTag,
  input  logic          xferToLink,
  input  logic [LW-1:0] xferLen,
  output logic          xferDone,
  output logic          xferOk,
  output logic          memValid,
  input  logic          memReady,
  output logic          memWrite,
  output logic [63:0]   memAddr,
  output logic [LW-1:0] memLen,
  output logic [31:0]   memWData,
  input  logic          memRespValid,
  input  logic [127:0]  memRData
);
  dmaStrobe_t    strobe;
  logic [SW-1:0] curStream;
  logic [IW-1:0] fetchCnt, fetchLast;
  logic [LW-1:0] left, chunk;
  logic [NS-1:0] runVec, fetchPendVec;
  logic [NS*4-1:0] tagFlat;
  logic [63:0]   fetchAddr, moveAddr, posWrAddr;
  logic [31:0]   posWrData;
  logic          willIrq, posEn;

  bdesc_dma_ctrl #(.NS(NS), .DD(DD), .LW(LW)) u_ctrl (
    .clk, .rstN, .xferValid, .xferTag, .xferToLink, .xferLen, .xferDone, .xferOk,
    .memValid, .memReady, .memWrite, .memAddr, .memLen, .memWData, .memRespValid,
    .runVec, .cmplVec(cmplPend), .fetchPendVec, .tagFlat, .fetchLast, .fetchAddr,
    .chunk, .moveAddr, .willIrq, .posEn, .posWrAddr, .posWrData,
    .strobe, .curStream, .fetchCnt, .left
  );

  bdesc_dma_dpath #(.NS(NS), .DD(DD), .LW(LW)) u_dpath (
    .clk, .rstN, .cfgWe, .cfgStream, .cfgSel, .cfgData, .strobe, .curStream,
    .fetchCnt, .left, .memRData, .runVec, .cmplVec(cmplPend), .fetchPendVec,
    .tagFlat, .fetchLast, .fetchAddr, .chunk, .moveAddr, .willIrq, .posEn,
    .posWrAddr, .posWrData, .posOut
  );
endmodule

// File: tb/bdesc_stream_dma_tb.sv
module bdesc_stream_dma_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWe = 1'b0;
  logic [1:0]   cfgStream = '0;
  logic [2:0]   cfgSel = '0;
  logic [31:0]  cfgData = '0;
  logic [31:0]  posOut;
  logic [3:0]   cmplPend;
  logic         xferValid = 1'b0;
  logic [3:0]   xferTag = '0;
  logic         xferToLink = 1'b0;
  logic [15:0]  xferLen = '0;
  logic         xferDone, xferOk;
  logic         memValid, memWrite;
  logic         memReady = 1'b0;
  logic [63:0]  memAddr;
  logic [15:0]  memLen;
  logic [31:0]  memWData;
  logic         memRespValid = 1'b0;
  logic [127:0] memRData = '0;

  always #2 clk = ~clk;

  bdesc_stream_dma u_dut (.*);

  typedef struct packed {
    logic        wr;
    logic [63:0] addr;
    logic [15:0] len;
    logic        chkData;
    logic [31:0] wd;
  } memItem_t;

  memItem_t expMem[$];
  string    expMemTag[$];
  logic     expOk[$];
  string    expOkTag[$];
  int       nChecks = 0;
  int       nFails  = 0;
  bit       finished = 0;

  localparam logic [63:0] LIST_BASE = 64'h2_0000_1000;
  logic [63:0] tAddr [4];
  logic [31:0] tLen  [4];
  logic [31:0] tFlg  [4];
  int unsigned readyCnt = 0;

  // memory model: stalls every third cycle, answers one cycle after accept
  always @(posedge clk) begin
    readyCnt     <= readyCnt + 1;
    memReady     <= (readyCnt % 3) != 2;
    memRespValid <= memValid && memReady;
    if (memValid && memReady) begin
      logic [63:0] di;
      di = (memAddr - LIST_BASE) >> 4;
      memRData <= {tFlg[di[1:0]], tLen[di[1:0]], tAddr[di[1:0]]};
    end
  end

  task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memValid && memReady) begin
      if (expMem.size() == 0) begin
        check("R2/R3", "unexpected memory request addr", memAddr, 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        memItem_t e;
        string    t;
        e = expMem.pop_front();
        t = expMemTag.pop_front();
        check(t, "mem write flag", {63'b0, memWrite}, {63'b0, e.wr});
        check(t, "mem addr", memAddr, e.addr);
        check(t, "mem len", {48'b0, memLen}, {48'b0, e.len});
        if (e.chkData) check(t, "mem wdata", {32'b0, memWData}, {32'b0, e.wd});
      end
    end
    if (rstN && xferDone) begin
      if (expOk.size() == 0) begin
        check("R2", "unexpected xferDone", 64'd1, 64'd0);
      end else begin
        logic  eo;
        string t;
        eo = expOk.pop_front();
        t  = expOkTag.pop_front();
        check(t, "xferOk", {63'b0, xferOk}, {63'b0, eo});
      end
    end
  end

  task automatic pushMem(string rq, logic wr, logic [63:0] addr, logic [15:0] len);
    expMem.push_back('{wr: wr, addr: addr, len: len, chkData: 1'b0, wd: 32'd0});
    expMemTag.push_back(rq);
  endtask

  task automatic pushPos(string rq, logic [63:0] addr, logic [31:0] wd);
    expMem.push_back('{wr: 1'b1, addr: addr, len: 16'd4, chkData: 1'b1, wd: wd});
    expMemTag.push_back(rq);
  endtask

  task automatic cfgWrite(logic [1:0] s, logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgStream = s; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doXfer(string rq, logic [3:0] tag, logic toLink, logic [15:0] len, logic ok);
    expOk.push_back(ok);
    expOkTag.push_back(rq);
    @(negedge clk);
    xferValid = 1'b1; xferTag = tag; xferToLink = toLink; xferLen = len;
    @(negedge clk);
    while (!xferDone) @(negedge clk);
    xferValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pushFetch(string rq);
    for (int i = 0; i < 3; i++) pushMem(rq, 1'b0, LIST_BASE + 64'(16 * i), 16'd16);
  endtask

  localparam logic [31:0] CTL_RUN5 = (32'd5 << 20) | 32'd2;

  initial begin
    for (int i = 0; i < 4; i++) begin
      tAddr[i] = 64'h8000_0000 + 64'(i * 32'h1000);
      tLen[i]  = 32'd40;
      tFlg[i]  = (i == 1) ? 32'd1 : 32'd0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "reset cmplPend", {60'b0, cmplPend}, 64'd0);
    check("R9", "reset posOut", {32'b0, posOut}, 64'd0);
    check("R11", "reset memValid", {63'b0, memValid}, 64'd0);

    cfgWrite(2'd1, 3'd1, 32'd100);
    cfgWrite(2'd1, 3'd2, 32'd2);
    cfgWrite(2'd1, 3'd3, LIST_BASE[31:0]);
    cfgWrite(2'd1, 3'd4, LIST_BASE[63:32]);
    cfgWrite(2'd0, 3'd0, 32'd7 << 20);          // stream 0: tag 7, stopped
    pushFetch("R1");
    cfgWrite(2'd1, 3'd0, CTL_RUN5);
    repeat (30) @(negedge clk);
    check("R1", "descriptor reads outstanding", 64'(expMem.size()), 64'd0);

    pushMem("R4", 1'b0, 64'h8000_0000, 16'd30);
    doXfer("R4", 4'd5, 1'b1, 16'd30, 1'b1);
    pushMem("R5", 1'b1, 64'h8000_001E, 16'd10);
    pushMem("R5", 1'b1, 64'h8000_1000, 16'd20);
    doXfer("R5", 4'd5, 1'b0, 16'd30, 1'b1);
    check("R5", "posOut after two requests", {32'b0, posOut}, 64'd60);
    check("R6", "no completion yet", {60'b0, cmplPend}, 64'd0);

    pushMem("R7", 1'b0, 64'h8000_1014, 16'd20);
    pushMem("R7", 1'b0, 64'h8000_2000, 16'd20);
    pushMem("R7", 1'b0, 64'h8000_2014, 16'd10);
    doXfer("R6", 4'd5, 1'b1, 16'd50, 1'b1);
    check("R7", "posOut wrapped", {32'b0, posOut}, 64'd10);
    check("R6", "completion raised", {60'b0, cmplPend}, 64'd2);

    doXfer("R3", 4'd5, 1'b1, 16'd8, 1'b0);
    check("R3", "posOut unchanged while pending", {32'b0, posOut}, 64'd10);
    cfgWrite(2'd1, 3'd0, CTL_RUN5 | (32'd1 << 26));
    check("R3", "completion cleared", {60'b0, cmplPend}, 64'd0);

    cfgWrite(2'd0, 3'd5, 32'h0000_3001);
    cfgWrite(2'd0, 3'd6, 32'h0000_0000);
    pushMem("R8", 1'b0, 64'h8000_201E, 16'd10);
    pushPos("R8", 64'h3008, 32'd20);
    doXfer("R8", 4'd5, 1'b1, 16'd10, 1'b1);
    pushMem("R5", 1'b0, 64'h8000_0000, 16'd5);
    pushPos("R5", 64'h3008, 32'd25);
    doXfer("R5", 4'd5, 1'b1, 16'd5, 1'b1);

    doXfer("R2", 4'd9, 1'b1, 16'd4, 1'b0);
    doXfer("R2", 4'd7, 1'b1, 16'd4, 1'b0);

    cfgWrite(2'd1, 3'd0, 32'd1);
    check("R9", "posOut after stream reset", {32'b0, posOut}, 64'd0);
    doXfer("R9", 4'd5, 1'b1, 16'd4, 1'b0);

    pushFetch("R10");
    cfgWrite(2'd1, 3'd0, CTL_RUN5);
    repeat (30) @(negedge clk);
    pushMem("R10", 1'b0, 64'h8000_0000, 16'd12);
    pushPos("R10", 64'h3008, 32'd12);
    doXfer("R10", 4'd5, 1'b1, 16'd12, 1'b1);
    check("R11", "all expected requests seen", 64'(expMem.size()), 64'd0);
    check("R2", "all expected completions seen", 64'(expOk.size()), 64'd0);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule